// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a scalar floating-point unit. Software loads and reads the whole word through a plain register port. The arithmetic unit reports each finished operation through a side port. A report carries a six-bit exception vector and, for compare operations, one condition code to set or clear. From this state the block drives the rounding mode and the flush-to-zero control to the datapath. It also raises a trap request when an unmasked exception is present. Branch logic reads a packed eight-bit condition vector.

The word holds five things: a rounding-mode field, a flush control, a per-operation cause field, an enable mask and a sticky flag field. It also holds eight condition codes. The codes are not contiguous: code 0 sits below the flush bit and codes 1 to 7 sit above it. The cause field is reloaded on every report. The flag field only gathers bits, and it is left alone when the report traps.

Top module: `fpu_csr`

## Requirements
- R1: After reset, rd_data, trap_req, round_mode, flush_zero and cond_vec are all zero.
- R2: A software write loads the word one cycle later, masked with 32'hFF83_FFFF. Bits 22:18 are reserved and always read as zero.
- R3: round_mode mirrors bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf). flush_zero mirrors bit 24. Both follow the stored word with no extra delay.
- R4: An operation report replaces the cause field, bits 17:12, with op_exc. The exception bits are: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid, bit5 unimplemented.
- R5: A report that does not trap ORs op_exc[4:0] into the flag field, bits 6:2. The enable field, bits 11:7, is never changed by a report.
- R6: trap_req is high while (cause[4:0] & enable) is nonzero or cause bit 5 is set. A report traps when op_exc under the current enable meets that rule. A trapping report leaves the flag field unchanged.
- R7: A compare report writes op_cmp_val into condition code op_cmp_idx. Code 0 is at bit 23 and code n (1..7) is at bit 24+n. All other bits are left untouched.
- R8: cond_vec[0] equals bit 23 and cond_vec[7:1] equals bits 31:25.
- R9: When a software write and a report arrive in the same cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write word |
| op_valid | input | 1 | Operation report strobe |
| op_exc | input | 6 | Exception bits of the reported operation |
| op_cmp_en | input | 1 | Report carries a compare result |
| op_cmp_idx | input | 3 | Condition code addressed by the compare |
| op_cmp_val | input | 1 | Compare outcome to store |
| rd_data | output | 32 | Current register word |
| trap_req | output | 1 | Unmasked exception pending |
| round_mode | output | 2 | Rounding mode to datapath |
| flush_zero | output | 1 | Flush-to-zero control |
| cond_vec | output | 8 | Packed condition codes |

## Verification
The bench first writes all-ones and all-zeros words. This separates the reserved-bit mask from the writable fields. Reports with different exception bits, one after another, show that the cause field is replaced while the flags accumulate. Reports under a nonzero enable, and reports carrying the unimplemented bit, separate trapping reports from non-trapping ones. Compares on codes 0, 3 and 7 expose a wrong bit position for the split code layout. A write arriving with a report in the same cycle shows which of the two wins.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;
    localparam int WORD_W   = 32;
    localparam int CC_NUM   = 8;
    localparam int CC_IDX_W = $clog2(CC_NUM);
    localparam int EXC_W    = 6;
    localparam int STK_W    = EXC_W - 1;
    localparam int RM_W     = 2;

    localparam int CC0_POS   = 23;
    localparam int FZ_POS    = 24;
    localparam int CCHI_BASE = 24;
    localparam int CAUSE_LO  = 12;
    localparam int EN_LO     = 7;
    localparam int FLG_LO    = 2;
    localparam int RM_LO     = 0;

    localparam logic [WORD_W-1:0] WR_MASK = 32'hFF83_FFFF;

    typedef struct packed {
        logic [CC_NUM-1:0] cc;
        logic              fz;
        logic [EXC_W-1:0]  cause;
        logic [STK_W-1:0]  en;
        logic [STK_W-1:0]  flg;
        logic [RM_W-1:0]   rm;
    } csr_t;
endpackage

// File: rtl/fpu_csr_next.sv
module fpu_csr_next
    import fpu_csr_pkg::*;
(
    input  csr_t                cur,
    input  logic                sw_wr_en,
    input  logic [WORD_W-1:0]   sw_wr_data,
    input  logic                op_valid,
    input  logic [EXC_W-1:0]    op_exc,
    input  logic                op_cmp_en,
    input  logic [CC_IDX_W-1:0] op_cmp_idx,
    input  logic                op_cmp_val,
    output csr_t                nxt
);
    logic [WORD_W-1:0] wr_m;
    logic              op_trap;

    always_comb begin
        wr_m    = sw_wr_data & WR_MASK;
        op_trap = (|(op_exc[STK_W-1:0] & cur.en)) | op_exc[EXC_W-1];
        nxt     = cur;
        if (sw_wr_en) begin
            nxt.cc[0] = wr_m[CC0_POS];
            for (int k = 1; k < CC_NUM; k++) begin
                nxt.cc[k] = wr_m[CCHI_BASE + k];
            end
            nxt.fz    = wr_m[FZ_POS];
            nxt.cause = wr_m[CAUSE_LO +: EXC_W];
            nxt.en    = wr_m[EN_LO +: STK_W];
            nxt.flg   = wr_m[FLG_LO +: STK_W];
            nxt.rm    = wr_m[RM_LO +: RM_W];
        end else begin
            if (op_valid) begin
                nxt.cause = op_exc;
                if (!op_trap) begin
                    nxt.flg = cur.flg | op_exc[STK_W-1:0];
                end
            end
            if (op_cmp_en) begin
                nxt.cc[op_cmp_idx] = op_cmp_val;
            end
        end
    end
endmodule

// File: rtl/fpu_csr_view.sv
module fpu_csr_view
    import fpu_csr_pkg::*;
(
    input  csr_t              st,
    output logic [WORD_W-1:0] rd_word,
    output logic [CC_NUM-1:0] cc_packed,
    output logic              trap_out
);
    logic [WORD_W-1:0] base_word;

    always_comb begin
        base_word                      = '0;
        base_word[CC0_POS]             = st.cc[0];
        base_word[FZ_POS]              = st.fz;
        base_word[CAUSE_LO +: EXC_W]   = st.cause;
        base_word[EN_LO +: STK_W]      = st.en;
        base_word[FLG_LO +: STK_W]     = st.flg;
        base_word[RM_LO +: RM_W]       = st.rm;
    end

    logic [CC_NUM-1:0] hi_bits;
    assign hi_bits[0] = 1'b0;
    for (genvar g = 1; g < CC_NUM; g++) begin : g_cc_hi
        assign hi_bits[g] = st.cc[g];
    end

    always_comb begin
        rd_word = base_word;
        for (int k = 1; k < CC_NUM; k++) begin
            rd_word[CCHI_BASE + k] = hi_bits[k];
        end
    end

    assign cc_packed = {rd_word[WORD_W-1:CCHI_BASE+1], rd_word[CC0_POS]};
    assign trap_out  = (|(st.cause[STK_W-1:0] & st.en)) | st.cause[EXC_W-1];
endmodule

// File: rtl/fpu_csr.sv
module fpu_csr
    import fpu_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr_en,
    input  logic [WORD_W-1:0]   sw_wr_data,
    input  logic                op_valid,
    input  logic [EXC_W-1:0]    op_exc,
    input  logic                op_cmp_en,
    input  logic [CC_IDX_W-1:0] op_cmp_idx,
    input  logic                op_cmp_val,
    output logic [WORD_W-1:0]   rd_data,
    output logic                trap_req,
    output logic [RM_W-1:0]     round_mode,
    output logic                flush_zero,
    output logic [CC_NUM-1:0]   cond_vec
);
    csr_t st_q;
    csr_t st_d;
    csr_t upd;

    fpu_csr_next u_next (
        .cur        (st_q),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .op_valid   (op_valid),
        .op_exc     (op_exc),
        .op_cmp_en  (op_cmp_en),
        .op_cmp_idx (op_cmp_idx),
        .op_cmp_val (op_cmp_val),
        .nxt        (upd)
    );

    always_comb begin
        st_d = upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fpu_csr_view u_view (
        .st        (st_q),
        .rd_word   (rd_data),
        .cc_packed (cond_vec),
        .trap_out  (trap_req)
    );

    assign round_mode = st_q.rm;
    assign flush_zero = st_q.fz;
endmodule

// File: rtl/fpu_csr_checker.sv
module fpu_csr_checker
    import fpu_csr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                sw_wr_en,
    input logic [WORD_W-1:0]   sw_wr_data,
    input logic                op_valid,
    input logic [EXC_W-1:0]    op_exc,
    input logic                op_cmp_en,
    input logic [CC_IDX_W-1:0] op_cmp_idx,
    input logic                op_cmp_val,
    input logic [WORD_W-1:0]   rd_data,
    input logic                trap_req,
    input logic [RM_W-1:0]     round_mode,
    input logic                flush_zero,
    input logic [CC_NUM-1:0]   cond_vec
);
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> rd_data == ($past(sw_wr_data) & WR_MASK)); // R2, R9
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[22:18] == 5'd0); // R2
    AST_CTRL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        round_mode == rd_data[1:0] && flush_zero == rd_data[FZ_POS]); // R3
    AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr_en) |=> rd_data[17:12] == $past(op_exc)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> (rd_data[6:2] & $past(rd_data[6:2])) == $past(rd_data[6:2])); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> rd_data[11:7] == $past(rd_data[11:7])); // R5
    AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req == ((|(rd_data[16:12] & rd_data[11:7])) | rd_data[17])); // R6
    AST_TRAP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr_en && ((|(op_exc[4:0] & rd_data[11:7])) || op_exc[5]))
        |=> rd_data[6:2] == $past(rd_data[6:2])); // R6
    AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cmp_en && !sw_wr_en) |=> cond_vec[$past(op_cmp_idx)] == $past(op_cmp_val)); // R7
    AST_CMP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cmp_en && !sw_wr_en) |=>
        ((cond_vec ^ $past(cond_vec)) & ~(8'b1 << $past(op_cmp_idx))) == 8'd0); // R7
    AST_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        cond_vec == {rd_data[31:25], rd_data[23]}); // R8
endmodule

bind fpu_csr fpu_csr_checker u_fpu_csr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .op_valid   (op_valid),
    .op_exc     (op_exc),
    .op_cmp_en  (op_cmp_en),
    .op_cmp_idx (op_cmp_idx),
    .op_cmp_val (op_cmp_val),
    .rd_data    (rd_data),
    .trap_req   (trap_req),
    .round_mode (round_mode),
    .flush_zero (flush_zero),
    .cond_vec   (cond_vec)
);

// File: tb/fpu_csr_bench.sv
module fpu_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_exc = '0;
    logic        op_cmp_en = 1'b0;
    logic [2:0]  op_cmp_idx = '0;
    logic        op_cmp_val = 1'b0;
    logic [31:0] rd_data;
    logic        trap_req;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic [7:0]  cond_vec;

    always #5 clk = ~clk;

    fpu_csr u_fpu_csr (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .op_valid(op_valid), .op_exc(op_exc), .op_cmp_en(op_cmp_en),
        .op_cmp_idx(op_cmp_idx), .op_cmp_val(op_cmp_val), .rd_data(rd_data),
        .trap_req(trap_req), .round_mode(round_mode), .flush_zero(flush_zero),
        .cond_vec(cond_vec)
    );

    typedef struct {
        logic [31:0] rd;
        logic        trap;
        logic [1:0]  rm;
        logic        fz;
        logic [7:0]  cc;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] model = '0;
    bit          done = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push_expect(input string tag);
        exp_t e;
        e.rd   = model;
        e.trap = (|(model[16:12] & model[11:7])) | model[17];
        e.rm   = model[1:0];
        e.fz   = model[24];
        e.cc   = {model[31:25], model[23]};
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "rd_data", rd_data, e.rd);
                chk(e.tag, "trap_req", {31'd0, trap_req}, {31'd0, e.trap});
                chk(e.tag, "round_mode", {30'd0, round_mode}, {30'd0, e.rm});
                chk(e.tag, "flush_zero", {31'd0, flush_zero}, {31'd0, e.fz});
                chk(e.tag, "cond_vec", {24'd0, cond_vec}, {24'd0, e.cc});
            end
        end
    end

    // Driver: applies one cycle of stimulus, updates the model, pushes the expectation
    task automatic step(input logic wr, input logic [31:0] wd, input logic ov,
                        input logic [5:0] exc, input logic ce, input logic [2:0] ci,
                        input logic cv, input string tag);
        logic trap;
        @(negedge clk);
        sw_wr_en = wr; sw_wr_data = wd; op_valid = ov; op_exc = exc;
        op_cmp_en = ce; op_cmp_idx = ci; op_cmp_val = cv;
        if (wr) begin
            model = wd & 32'hFF83_FFFF;
        end else begin
            if (ov) begin
                trap = (|(exc[4:0] & model[11:7])) | exc[5];
                model[17:12] = exc;
                if (!trap) model[6:2] = model[6:2] | exc[4:0];
            end
            if (ce) begin
                if (ci == 3'd0) model[23] = cv;
                else            model[24 + int'(ci)] = cv;
            end
        end
        @(posedge clk);
        #1;
        sw_wr_en = 1'b0; op_valid = 1'b0; op_cmp_en = 1'b0;
        push_expect(tag);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        model = '0;
        push_expect("R1");
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        // R2: mask and reserved bits
        step(1, 32'hFFFF_FFFF, 0, 6'd0, 0, 3'd0, 0, "R2");
        step(1, 32'h0000_0000, 0, 6'd0, 0, 3'd0, 0, "R2");
        step(1, 32'h007C_0000, 0, 6'd0, 0, 3'd0, 0, "R2");
        // R3: rounding modes and flush control
        step(1, 32'h0000_0001, 0, 6'd0, 0, 3'd0, 0, "R3");
        step(1, 32'h0000_0002, 0, 6'd0, 0, 3'd0, 0, "R3");
        step(1, 32'h0100_0003, 0, 6'd0, 0, 3'd0, 0, "R3");
        // R4, R5: cause replaced, flags accumulate, enable kept
        step(1, 32'h0000_0000, 0, 6'd0, 0, 3'd0, 0, "R5");
        step(0, 32'h0, 1, 6'h01, 0, 3'd0, 0, "R4");
        step(0, 32'h0, 1, 6'h04, 0, 3'd0, 0, "R5");
        step(0, 32'h0, 1, 6'h12, 0, 3'd0, 0, "R5");
        step(0, 32'h0, 1, 6'h00, 0, 3'd0, 0, "R4");
        // R6: trap on enabled divide-by-zero and on unimplemented
        step(1, 32'h0000_0400, 0, 6'd0, 0, 3'd0, 0, "R6");
        step(0, 32'h0, 1, 6'h09, 0, 3'd0, 0, "R6");
        step(0, 32'h0, 1, 6'h01, 0, 3'd0, 0, "R6");
        step(0, 32'h0, 1, 6'h22, 0, 3'd0, 0, "R6");
        step(0, 32'h0, 1, 6'h00, 0, 3'd0, 0, "R6");
        // R7, R8: compare codes at split positions
        step(0, 32'h0, 0, 6'd0, 1, 3'd0, 1, "R7");
        step(0, 32'h0, 0, 6'd0, 1, 3'd3, 1, "R7");
        step(0, 32'h0, 0, 6'd0, 1, 3'd7, 1, "R8");
        step(0, 32'h0, 0, 6'd0, 1, 3'd1, 1, "R8");
        step(0, 32'h0, 0, 6'd0, 1, 3'd3, 0, "R7");
        step(0, 32'h0, 1, 6'h04, 1, 3'd0, 0, "R7");
        // R9: write wins over same-cycle report and compare
        step(1, 32'h0000_0180, 1, 6'h3F, 1, 3'd5, 1, "R9");
        step(1, 32'h8080_0000, 1, 6'h01, 1, 3'd7, 0, "R9");
        repeat (2) @(posedge clk);
        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule